// File: doc/BRIEF.md
# Time-aware gate scheduler

This block opens and closes the transmit gates of up to eight traffic classes on one egress port according to a repeating time schedule. Software fills a staging list of entries, one at a time. Each entry holds a gate mask and a duration in nanoseconds. Software also writes a base time, a cycle length, a cycle stretch allowance and a list length, then issues a commit. The block checks the configuration and reports a status one cycle later, with zero meaning accepted.

An accepted configuration waits until its start time arrives and then replaces the running schedule in a single clock edge. Until then the running schedule carries on untouched. The block compares its stored boundaries against a free-running 64-bit nanosecond time counter. It advances through the running list and raises a one-hot-per-class gate-open vector.

The block assumes the time counter grows by less per clock than the shortest entry duration or cycle length.

Top module: `tas_gate_sched`

## Requirements
- R1: After reset, and whenever no schedule is running (including while a committed schedule waits for its start time), every bit of `gate_open` is 1.
- R2: While a schedule runs, `gate_open` shows the mask of entry 0 from the cycle start for that entry's duration, then the mask of each following entry in index order for its own duration.
- R3: When the entry durations add up to less than the cycle length, the mask of the last entry stays applied until the cycle ends.
- R4: When the entry durations add up to more than the cycle length, the list is cut off at the cycle end and the next cycle begins again at entry 0.
- R5: A committed base time of zero is replaced by the time counter value sampled on the commit edge. The base time is written as two halves: `cfg_sel` 0 sets bits 31:0 and `cfg_sel` 1 sets bits 63:32.
- R6: A nonzero base time that is already in the past is moved forward by whole cycle lengths to the first value at or after the current time. The schedule keeps the phase of the written base.
- R7: `cmd_done` pulses high on the cycle after `commit`. `cmd_status` is 1 and the configuration is discarded when the list length (`cfg_sel` 4) is 0 or greater than `MAX_ENT`, or when the cycle length (`cfg_sel` 2) is 0. Otherwise `cmd_status` is 0.
- R8: Entry writes and a commit do not change the running schedule. The new schedule takes over on the first edge at which the time counter has reached its start time.
- R9: When a cycle ends and the pending start time lies less than the stretch allowance (`cfg_sel` 3) after that cycle end, no new cycle starts. The current mask is held until the pending schedule takes over.
- R10: Driving `gate_en` low stops the running schedule and opens all gates from the next cycle. A commit made while it is low starts, once `gate_en` is high again, at a cycle boundary in the phase of its base time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| now_ns | input | 64 | Free-running nanosecond time counter |
| gate_en | input | 1 | Scheduling enable |
| ent_wr | input | 1 | Write strobe for a staging list entry |
| ent_idx | input | $clog2(MAX_ENT) | Entry index |
| ent_mask | input | NUM_TC | Gate mask for the entry, 1 = open |
| ent_ivl | input | 32 | Entry duration in ns |
| cfg_wr | input | 1 | Write strobe for a scalar setting |
| cfg_sel | input | 3 | Setting select: 0 base low, 1 base high, 2 cycle, 3 stretch, 4 length |
| cfg_data | input | 32 | Setting value |
| commit | input | 1 | Check and arm the staged configuration |
| cmd_done | output | 1 | One-cycle pulse after a commit |
| cmd_status | output | 1 | 0 = accepted, 1 = rejected |
| gate_open | output | NUM_TC | Per-class transmit gate open |

## Verification
Random lists of one to sixteen entries with random masks and durations are paired with cycle lengths drawn both below and above the duration sum. Comparing each clock against a time-driven model therefore separates the hold-last-mask case from the truncation case. Each random schedule is committed while the previous one runs, with a start time a few hundred ns ahead. This catches any disturbance of the running list and any swap that comes early or late. Directed cases cover a zero base time, a base time in the past while disabled, rejected lengths and cycle lengths, and a pending start time inside the stretch window. The last case tells a stretched cycle apart from a short extra cycle.

// File: rtl/tas_gate_sched.sv
module tas_gate_sched #(
  parameter int NUM_TC  = 8,
  parameter int MAX_ENT = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [63:0]                now_ns,
  input  logic                       gate_en,
  input  logic                       ent_wr,
  input  logic [$clog2(MAX_ENT)-1:0] ent_idx,
  input  logic [NUM_TC-1:0]          ent_mask,
  input  logic [31:0]                ent_ivl,
  input  logic                       cfg_wr,
  input  logic [2:0]                 cfg_sel,
  input  logic [31:0]                cfg_data,
  input  logic                       commit,
  output logic                       cmd_done,
  output logic                       cmd_status,
  output logic [NUM_TC-1:0]          gate_open
);
  localparam int IDX_W = $clog2(MAX_ENT);
  localparam int LEN_W = IDX_W + 1;
  localparam int DEPTH = 2 * MAX_ENT;
  localparam logic [15:0] MAX_LEN = 16'(MAX_ENT);

  logic [NUM_TC-1:0] mask_q [DEPTH];
  logic [31:0]       ivl_q  [DEPTH];

  logic [63:0] a_base;
  logic [31:0] a_cycle, a_ext;
  logic [15:0] a_len;

  logic             p_val, p_fix;
  logic [63:0]      p_base;
  logic [31:0]      p_cycle, p_ext;
  logic [LEN_W-1:0] p_len;

  logic             run_q, bank_q, hold_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] o_len;
  logic [31:0]      o_cycle;
  logic [63:0]      cyc_start, ent_end;
  logic             done_q, stat_q;

  always_ff @(posedge clk) begin
    if (ent_wr) begin
      mask_q[{~bank_q, ent_idx}] <= ent_mask;
      ivl_q[{~bank_q, ent_idx}]  <= ent_ivl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_base  <= '0;
      a_cycle <= '0;
      a_ext   <= '0;
      a_len   <= '0;
    end else if (cfg_wr) begin
      case (cfg_sel)
        3'd0:    a_base[31:0]  <= cfg_data;
        3'd1:    a_base[63:32] <= cfg_data;
        3'd2:    a_cycle       <= cfg_data;
        3'd3:    a_ext         <= cfg_data;
        3'd4:    a_len         <= cfg_data[15:0];
        default: ;
      endcase
    end
  end

  wire cfg_ok    = (a_len != 16'd0) && (a_len <= MAX_LEN) && (a_cycle != 32'd0);
  wire base_zero = (a_base == 64'd0);

  wire [63:0]      cyc_end  = cyc_start + {32'd0, o_cycle};
  wire [IDX_W-1:0] nxt_idx  = idx_q + 1'b1;
  wire             last_ent = ({1'b0, idx_q} == o_len - 1'b1);
  wire             p_ready  = p_val && !p_fix;
  wire             swap_go  = gate_en && p_ready && (now_ns >= p_base);
  wire [63:0]      gap      = p_base - cyc_end;
  wire             stretch  = p_ready && (p_base > cyc_end) && (gap < {32'd0, p_ext});
  wire             adv_base = p_val && (p_base < now_ns) && (p_fix || !gate_en);

  wire [31:0] ivl_new0 = ivl_q[{~bank_q, {IDX_W{1'b0}}}];
  wire [31:0] ivl_cur0 = ivl_q[{bank_q, {IDX_W{1'b0}}}];
  wire [31:0] ivl_nxt  = ivl_q[{bank_q, nxt_idx}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      stat_q    <= 1'b0;
      p_val     <= 1'b0;
      p_fix     <= 1'b0;
      p_base    <= '0;
      p_cycle   <= '0;
      p_ext     <= '0;
      p_len     <= '0;
      run_q     <= 1'b0;
      bank_q    <= 1'b0;
      hold_q    <= 1'b0;
      idx_q     <= '0;
      o_len     <= '0;
      o_cycle   <= '0;
      cyc_start <= '0;
      ent_end   <= '0;
    end else begin
      done_q <= commit;
      if (commit) stat_q <= !cfg_ok;

      if (adv_base) p_base <= p_base + {32'd0, p_cycle};
      else          p_fix  <= 1'b0;
      if (swap_go)  p_val  <= 1'b0;
      if (commit && cfg_ok) begin
        p_val   <= 1'b1;
        p_fix   <= !base_zero;
        p_base  <= base_zero ? now_ns : a_base;
        p_cycle <= a_cycle;
        p_ext   <= a_ext;
        p_len   <= a_len[LEN_W-1:0];
      end

      if (!gate_en) begin
        run_q <= 1'b0;
      end else if (swap_go) begin
        run_q     <= 1'b1;
        bank_q    <= ~bank_q;
        o_len     <= p_len;
        o_cycle   <= p_cycle;
        cyc_start <= p_base;
        idx_q     <= '0;
        hold_q    <= 1'b0;
        ent_end   <= p_base + {32'd0, ivl_new0};
      end else if (run_q) begin
        if (now_ns >= cyc_end) begin
          if (!stretch) begin
            cyc_start <= cyc_end;
            idx_q     <= '0;
            hold_q    <= 1'b0;
            ent_end   <= cyc_end + {32'd0, ivl_cur0};
          end
        end else if (!hold_q && now_ns >= ent_end) begin
          if (last_ent) begin
            hold_q <= 1'b1;
          end else begin
            idx_q   <= nxt_idx;
            ent_end <= ent_end + {32'd0, ivl_nxt};
          end
        end
      end
    end
  end

  assign cmd_done   = done_q;
  assign cmd_status = stat_q;
  assign gate_open  = run_q ? mask_q[{bank_q, idx_q}] : {NUM_TC{1'b1}};

endmodule

module tas_gate_sched_chk #(
  parameter int NUM_TC  = 8,
  parameter int MAX_ENT = 16,
  parameter int IDX_W   = 4,
  parameter int LEN_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gate_en,
  input logic              commit,
  input logic [15:0]       a_len,
  input logic              cmd_done,
  input logic              cmd_status,
  input logic [NUM_TC-1:0] gate_open,
  input logic              bank_q,
  input logic [63:0]       now_ns,
  input logic [63:0]       p_base,
  input logic              run_q,
  input logic [IDX_W-1:0]  idx_q,
  input logic [LEN_W-1:0]  o_len
);
  a_r10_open_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> (gate_open == {NUM_TC{1'b1}}));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> cmd_done);

  a_r7_reject_len: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (a_len == 16'd0 || a_len > 16'(MAX_ENT))) |=> cmd_status);

  a_r8_swap_at_base: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_q) |-> $past(now_ns >= p_base));

  a_r2_idx_in_list: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ({1'b0, idx_q} < o_len));
endmodule

bind tas_gate_sched tas_gate_sched_chk #(
  .NUM_TC(NUM_TC), .MAX_ENT(MAX_ENT), .IDX_W(IDX_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .commit(commit), .a_len(a_len),
  .cmd_done(cmd_done), .cmd_status(cmd_status), .gate_open(gate_open),
  .bank_q(bank_q), .now_ns(now_ns), .p_base(p_base), .run_q(run_q),
  .idx_q(idx_q), .o_len(o_len)
);

// File: tb/tas_gate_sched_bench.sv
`timescale 1ns/1ps
module tas_gate_sched_bench;
  localparam int NTC = 8;
  localparam int MAXE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] now_ns = 64'd1000;
  logic        gate_en = 1'b0;
  logic        ent_wr = 1'b0;
  logic [3:0]  ent_idx = '0;
  logic [7:0]  ent_mask = '0;
  logic [31:0] ent_ivl = '0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic        commit = 1'b0;
  logic        cmd_done, cmd_status;
  logic [7:0]  gate_open;

  tas_gate_sched #(.NUM_TC(NTC), .MAX_ENT(MAXE)) u_tas_gate_sched (
    .clk(clk), .rst_n(rst_n), .now_ns(now_ns), .gate_en(gate_en),
    .ent_wr(ent_wr), .ent_idx(ent_idx), .ent_mask(ent_mask), .ent_ivl(ent_ivl),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .commit(commit),
    .cmd_done(cmd_done), .cmd_status(cmd_status), .gate_open(gate_open)
  );

  initial forever #4 clk = ~clk;
  initial forever begin @(posedge clk); now_ns <= now_ns + 64'd8; end

  int ntest = 0, nfail = 0;

  logic [7:0]  om [MAXE], nm [MAXE];
  logic [31:0] oi [MAXE], ni [MAXE];
  logic [63:0] ob, nb;
  logic [31:0] oc, nc;
  int          ol, nl;
  bit          have_old = 0, have_new = 0;
  logic [63:0] st_lo = '0, st_hi = '0;
  logic [7:0]  st_mask = '0;

  function automatic logic [7:0] gate_of(input bit sel, input logic [63:0] t);
    logic [63:0] b, off, acc;
    logic [31:0] c, iv;
    int l;
    b = sel ? nb : ob;
    c = sel ? nc : oc;
    l = sel ? nl : ol;
    if (t < b) return 8'hFF;
    off = (t - b) % {32'd0, c};
    acc = '0;
    for (int i = 0; i < l; i++) begin
      iv = sel ? ni[i] : oi[i];
      if (off < acc + {32'd0, iv}) return sel ? nm[i] : om[i];
      acc = acc + {32'd0, iv};
    end
    return sel ? nm[l-1] : om[l-1];
  endfunction

  function automatic logic [7:0] exp_now();
    logic [63:0] t;
    t = now_ns - 64'd8;
    if (t >= st_lo && t < st_hi) return st_mask;
    if (have_new && t >= nb) return gate_of(1'b1, t);
    if (have_old) return gate_of(1'b0, t);
    return 8'hFF;
  endfunction

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h (t=%0d)", tag, act, exp, now_ns - 64'd8);
    end
  endtask

  task automatic tick(input string tag);
    @(negedge clk);
    check8(gate_open, exp_now(), tag);
  endtask

  task automatic set_cfg(input logic [2:0] sel, input logic [31:0] d, input string tag);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
    tick(tag);
    cfg_wr = 1'b0;
  endtask

  task automatic do_commit(input bit exp_stat, input string tag, output logic [63:0] cur);
    commit = 1'b1;
    cur = now_ns;
    tick(tag);
    commit = 1'b0;
    check8({7'd0, cmd_done}, 8'd1, "R7 done");
    check8({7'd0, cmd_status}, {7'd0, exp_stat}, "R7 status");
  endtask

  task automatic load_cfg(input logic [63:0] base, input logic [31:0] ext, input bit arm, input string tag);
    logic [63:0] cur;
    for (int i = 0; i < nl; i++) begin
      ent_wr = 1'b1; ent_idx = 4'(i); ent_mask = nm[i]; ent_ivl = ni[i];
      tick(tag);
    end
    ent_wr = 1'b0;
    set_cfg(3'd0, base[31:0], tag);
    set_cfg(3'd1, base[63:32], tag);
    set_cfg(3'd2, nc, tag);
    set_cfg(3'd3, ext, tag);
    set_cfg(3'd4, 32'(nl), tag);
    do_commit(1'b0, tag, cur);
    if (arm) begin
      have_new = 1;
      nb = (base == 64'd0) ? cur : base;
    end
  endtask

  task automatic promote();
    for (int i = 0; i < MAXE; i++) begin om[i] = nm[i]; oi[i] = ni[i]; end
    ob = nb; oc = nc; ol = nl;
    have_old = 1; have_new = 0;
  endtask

  task automatic rand_cfg(input int mode);
    int sum;
    sum = 0;
    nl = 1 + int'($urandom % MAXE);
    for (int i = 0; i < nl; i++) begin
      nm[i] = 8'($urandom);
      ni[i] = 32'(8 + $urandom % 60);
      sum += int'(ni[i]);
    end
    if (mode == 0)      nc = 32'((sum / 2 < 8) ? 8 : sum / 2);
    else if (mode == 1) nc = 32'(sum + 40);
    else                nc = 32'(8 + $urandom % (sum + 60));
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    logic [63:0] cur, bound, pb;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check8(gate_open, 8'hFF, "R1 reset");
    check8({7'd0, cmd_done}, 8'd0, "R1 reset done");

    // R7: rejected configurations
    set_cfg(3'd2, 32'd100, "R7");
    set_cfg(3'd4, 32'd0, "R7");
    do_commit(1'b1, "R7 len0", cur);
    set_cfg(3'd4, 32'd17, "R7");
    do_commit(1'b1, "R7 len17", cur);
    set_cfg(3'd4, 32'd2, "R7");
    set_cfg(3'd2, 32'd0, "R7");
    do_commit(1'b1, "R7 cycle0", cur);
    gate_en = 1'b1;
    repeat (20) tick("R7 not applied");

    // R5 + R3: zero base, sum below cycle
    nl = 3; nc = 120;
    nm[0] = 8'h01; ni[0] = 24;
    nm[1] = 8'h02; ni[1] = 40;
    nm[2] = 8'h04; ni[2] = 16;
    load_cfg(64'd0, 32'd0, 1'b1, "R5");
    check8(gate_open, 8'hFF, "R1 before first entry");
    repeat (100) tick("R5/R3");
    promote();

    // R8 + R2/R3/R4: random lists swapped in while running
    for (int k = 0; k < 6; k++) begin
      rand_cfg(k < 2 ? k : 2);
      pb = now_ns + 64'(300 + $urandom % 200);
      load_cfg(pb, 32'd0, 1'b1, "R8 no-disturb");
      while (now_ns < nb + {31'd0, nc, 1'b0} + 64'd16) tick("R8/R2/R4");
      promote();
    end

    // R9: stretch
    nl = 2; nc = 100;
    nm[0] = 8'h0F; ni[0] = 40;
    nm[1] = 8'hF0; ni[1] = 60;
    pb = now_ns + 64'd300;
    load_cfg(pb, 32'd0, 1'b1, "R9 setup");
    while (now_ns < nb + 64'd220) tick("R2");
    promote();
    bound = ob + ((now_ns + 64'd300 - ob) / 64'd100 + 64'd1) * 64'd100;
    nl = 1; nc = 50; nm[0] = 8'hAA; ni[0] = 50;
    st_lo = bound; st_hi = bound + 64'd30; st_mask = 8'hF0;
    load_cfg(bound + 64'd30, 32'd50, 1'b1, "R9");
    while (now_ns < st_hi + 64'd300) tick("R9");
    promote();
    st_lo = '0; st_hi = '0;

    // R10 + R6: stop, then past base while disabled
    gate_en = 1'b0;
    have_old = 0; have_new = 0;
    @(negedge clk);
    repeat (10) tick("R10 stopped");
    nl = 4; nc = 200;
    nm[0] = 8'h11; ni[0] = 30;
    nm[1] = 8'h22; ni[1] = 50;
    nm[2] = 8'h44; ni[2] = 70;
    nm[3] = 8'h88; ni[3] = 90;
    pb = now_ns - 64'd605;
    load_cfg(pb, 32'd0, 1'b0, "R10");
    repeat (10) tick("R10 stopped");
    gate_en = 1'b1;
    repeat (60) @(negedge clk);
    have_new = 1; nb = pb;
    repeat (150) tick("R6/R10");

    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule